// File: doc/BRIEF.md
# Idle-Locked Serial Stream Descrambler

This block recovers plain data from a serial bit stream that the far end has XORed with the keystream of an 11-bit linear feedback register (recurrence k[t] = k[t-11] xor k[t-9], polynomial x^11 + x^9 + 1). One bit arrives per clock with a valid strobe, already converted to NRZ. Idle line code is all ones, so while the far end sends idle, every received bit is the inverse of the keystream bit. The block uses this to seed its local register from the line. It then checks that the following bits keep obeying the recurrence, and declares lock after a long unbroken run of them.

Once locked, every valid bit is XORed with the local keystream and presented at the output. A hold timer polices the lock. Each run of consecutive descrambled idle symbols (five ones each) of the configured length reloads the timer. If the timer runs out first, the block drops lock, clears its keystream state, pulses a loss indication and starts acquisition again. The default timer of 90,250 cycles is the 722 us window at 125 MHz. It is a parameter so that simulation can shrink it.

Top module: `stream_descrambler`

## Requirements
- R1: After reset, `locked`, `sync_lost` and `dout_vld` are all 0.
- R2: After reset or loss of lock, the first LFSR_LEN valid bits only seed the keystream register. Lock then needs IDLE_RUN further consecutive valid bits that each equal the inverse of the predicted keystream bit. `locked` rises in the cycle after the clock edge that accepts the last of those bits, so with the defaults that is the 51st valid idle bit.
- R3: A valid bit that breaks the prediction restarts the run of IDLE_RUN. A corrupted bit also breaks the predictions 9 and 11 bits later, so with the defaults lock comes after the 51st clean idle bit that follows it.
- R4: While locked, each valid bit is XORed with the next keystream bit. The result appears on `dout`, with `dout_vld` high, one cycle after that bit's clock edge.
- R5: `dout_vld` is 0 during acquisition. It is only ever high while `locked` is high, or in the single cycle when `sync_lost` is high.
- R6: If no re-arm occurs, `locked` stays high for exactly HOLD_CYC cycles. It then falls, and `sync_lost` is high for exactly one cycle, the first cycle with `locked` low.
- R7: A run of IDLE_SYMS×SYM_BITS consecutive descrambled ones re-arms the timer to HOLD_CYC. A re-arm on the very edge where the timer would expire keeps the lock. A run that is one bit short does not re-arm.
- R8: After a loss of lock, the keystream state is cleared and acquisition restarts with the full seeding and idle run of R2.
- R9: A clock cycle with `rx_vld` low does not advance the keystream, the acquisition counters or the idle monitor, and produces `dout_vld` = 0. The hold timer still counts that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_bit | input | 1 | Received scrambled NRZ bit |
| rx_vld | input | 1 | Qualifies `rx_bit` in this cycle |
| dout | output | 1 | Descrambled bit |
| dout_vld | output | 1 | Qualifies `dout` |
| locked | output | 1 | Registered lock flag |
| sync_lost | output | 1 | One-cycle pulse when the hold timer expires |

## Verification
Acquisition is driven with a clean scrambled idle stream, which gives the exact lock cycle. It is also driven with the same stream carrying one flipped bit, which shows whether the run restarts and how the bad history bit echoes at taps 9 and 11. Descrambling is tried with random payload interleaved with invalid cycles, and with slow alternating runs. Together these separate a wrong keystream from a keystream that advances on idle cycles. The hold timer is fed three patterns: runs of three ones, which never re-arm; a run of exactly the re-arm length that ends on the expiry edge; and a long all-ones stretch. These patterns separate the timer length, the priority of re-arm over expiry, and the reload value.

// File: rtl/sdscr_pkg.sv
package sdscr_pkg;

   typedef enum logic [1:0] {
      SD_FILL = 2'd0,
      SD_HUNT = 2'd1,
      SD_LOCK = 2'd2
   } sd_state_e;

endpackage

// File: rtl/sdscr_keygen.sv
// Keystream register: seeded from inverted received bits while hunting,
// free-running on its own recurrence while locked.
module sdscr_keygen #(
   parameter int unsigned LEN = 11,
   parameter int unsigned TAP = 9
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic step,
   input  logic seed_mode,
   input  logic rx_bit,
   output logic key_bit,
   output logic match
);

   logic [LEN-1:0] st;

   // st[0] is the newest keystream bit, st[LEN-1] the oldest
   assign key_bit = st[LEN-1] ^ st[TAP-1];
   assign match   = (~rx_bit) == key_bit;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st <= '0;
      end else if (clear) begin
         st <= '0;
      end else if (step) begin
         st <= {st[LEN-2:0], (seed_mode ? ~rx_bit : key_bit)};
      end
   end

endmodule

// File: rtl/sdscr_idlemon.sv
// Counts consecutive descrambled ones; flags each complete run of RUN_BITS.
module sdscr_idlemon #(
   parameter int unsigned RUN_BITS = 80
) (
   input  logic clk,
   input  logic rst_n,
   input  logic enable,
   input  logic step,
   input  logic dbit,
   output logic hit
);

   localparam int unsigned W = $clog2(RUN_BITS + 1);

   logic [W-1:0] run;

   assign hit = enable & step & dbit & (run == W'(RUN_BITS - 1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run <= '0;
      end else if (!enable) begin
         run <= '0;
      end else if (step) begin
         run <= (!dbit || hit) ? '0 : run + W'(1);
      end
   end

endmodule

// File: rtl/sdscr_holdtmr.sv
// Lock supervision countdown; re-arm wins over expiry on the same edge.
module sdscr_holdtmr #(
   parameter int unsigned HOLD = 90250
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic active,
   input  logic rearm,
   output logic expire
);

   localparam int unsigned W = $clog2(HOLD + 1);

   logic [W-1:0] cnt;

   assign expire = active & ~rearm & (cnt == W'(1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (start) begin
         cnt <= W'(HOLD);
      end else if (active) begin
         if (rearm)
            cnt <= W'(HOLD);
         else if (cnt != '0)
            cnt <= cnt - W'(1);
      end else begin
         cnt <= '0;
      end
   end

endmodule

// File: rtl/stream_descrambler.sv
module stream_descrambler
   import sdscr_pkg::*;
#(
   parameter int unsigned LFSR_LEN  = 11,
   parameter int unsigned LFSR_TAP  = 9,
   parameter int unsigned IDLE_RUN  = 40,
   parameter int unsigned HOLD_CYC  = 90250,
   parameter int unsigned IDLE_SYMS = 16,
   parameter int unsigned SYM_BITS  = 5,
   parameter bit          OUT_REG   = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rx_bit,
   input  logic rx_vld,
   output logic dout,
   output logic dout_vld,
   output logic locked,
   output logic sync_lost
);

   localparam int unsigned FW       = $clog2(LFSR_LEN + 1);
   localparam int unsigned RW       = $clog2(IDLE_RUN + 1);
   localparam int unsigned REARM_RUN = IDLE_SYMS * SYM_BITS;

   // elaboration-time parameter checks
   if (LFSR_TAP == 0 || LFSR_TAP >= LFSR_LEN) begin : g_bad_tap
      $error("LFSR_TAP must lie in 1..LFSR_LEN-1");
   end
   if (IDLE_RUN < 1) begin : g_bad_run
      $error("IDLE_RUN must be at least 1");
   end
   if (HOLD_CYC <= REARM_RUN) begin : g_bad_hold
      $error("HOLD_CYC must exceed the re-arm run length");
   end

   sd_state_e      state;
   logic [FW-1:0]  fill_cnt;
   logic [RW-1:0]  run_cnt;
   logic           key_bit;
   logic           match;
   logic           dbit;
   logic           lock_now;
   logic           idle_hit;
   logic           expire;
   logic           in_lock;

   assign in_lock  = (state == SD_LOCK);
   assign dbit     = rx_bit ^ key_bit;
   assign lock_now = (state == SD_HUNT) && rx_vld && match &&
                     (run_cnt == RW'(IDLE_RUN - 1));

   sdscr_keygen #(.LEN(LFSR_LEN), .TAP(LFSR_TAP)) u_keygen (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear     (expire),
      .step      (rx_vld),
      .seed_mode (!in_lock),
      .rx_bit    (rx_bit),
      .key_bit   (key_bit),
      .match     (match)
   );

   sdscr_idlemon #(.RUN_BITS(REARM_RUN)) u_idlemon (
      .clk    (clk),
      .rst_n  (rst_n),
      .enable (in_lock),
      .step   (rx_vld),
      .dbit   (dbit),
      .hit    (idle_hit)
   );

   sdscr_holdtmr #(.HOLD(HOLD_CYC)) u_holdtmr (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (lock_now),
      .active (in_lock),
      .rearm  (idle_hit),
      .expire (expire)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= SD_FILL;
         fill_cnt  <= '0;
         run_cnt   <= '0;
         sync_lost <= 1'b0;
      end else begin
         sync_lost <= expire;
         case (state)
            SD_FILL: begin
               if (rx_vld) begin
                  if (fill_cnt == FW'(LFSR_LEN - 1)) begin
                     state    <= SD_HUNT;
                     fill_cnt <= '0;
                  end else begin
                     fill_cnt <= fill_cnt + FW'(1);
                  end
               end
            end
            SD_HUNT: begin
               if (rx_vld) begin
                  if (!match) begin
                     run_cnt <= '0;
                  end else if (lock_now) begin
                     state   <= SD_LOCK;
                     run_cnt <= '0;
                  end else begin
                     run_cnt <= run_cnt + RW'(1);
                  end
               end
            end
            SD_LOCK: begin
               if (expire) begin
                  state    <= SD_FILL;
                  fill_cnt <= '0;
                  run_cnt  <= '0;
               end
            end
            default: state <= SD_FILL;
         endcase
      end
   end

   assign locked = in_lock;

   if (OUT_REG) begin : g_out_reg
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            dout     <= 1'b0;
            dout_vld <= 1'b0;
         end else begin
            dout_vld <= rx_vld & in_lock;
            if (rx_vld & in_lock)
               dout <= dbit;
         end
      end
   end else begin : g_out_comb
      assign dout     = dbit & in_lock;
      assign dout_vld = rx_vld & in_lock;
   end

endmodule

// File: rtl/sdscr_chk.sv
module sdscr_chk #(
   parameter int unsigned HOLD_CYC = 90250
) (
   input logic clk,
   input logic rst_n,
   input logic rx_vld,
   input logic locked,
   input logic sync_lost,
   input logic dout_vld,
   input logic rearm
);

   localparam int unsigned W = $clog2(HOLD_CYC + 2);

   logic [W-1:0] since;

   always_ff @(posedge clk) begin
      if (!rst_n)
         since <= '0;
      else if (!locked || rearm)
         since <= '0;
      else if (since != {W{1'b1}})
         since <= since + W'(1);
   end

   // R2
   lock_on_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(locked) |-> $past(rx_vld));

   // R5
   dvld_when_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dout_vld |-> (locked || sync_lost));

   // R6
   loss_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sync_lost |=> !sync_lost);

   // R6
   loss_drops_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sync_lost |-> (!locked && $past(locked)));

   // R6
   hold_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      locked |-> (since < W'(HOLD_CYC)));

   // R9
   idle_cycle_no_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!rx_vld && !locked) |=> !locked);

endmodule

bind stream_descrambler sdscr_chk #(.HOLD_CYC(HOLD_CYC)) u_sdscr_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .rx_vld    (rx_vld),
   .locked    (locked),
   .sync_lost (sync_lost),
   .dout_vld  (dout_vld),
   .rearm     (idle_hit)
);

// File: tb/stream_descrambler_bench.sv
module stream_descrambler_bench;

   localparam int HOLD = 300;
   localparam int SYMS = 4;
   localparam int SB   = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic rx_bit = 1'b0;
   logic rx_vld = 1'b0;
   logic dout, dout_vld, locked, sync_lost;
   logic [10:0] ref_st;
   int total = 0;
   int bad = 0;

   always #2 clk = ~clk;

   stream_descrambler #(
      .HOLD_CYC (HOLD),
      .IDLE_SYMS(SYMS),
      .SYM_BITS (SB)
   ) u_stream_descrambler (
      .clk(clk), .rst_n(rst_n), .rx_bit(rx_bit), .rx_vld(rx_vld),
      .dout(dout), .dout_vld(dout_vld), .locked(locked), .sync_lost(sync_lost)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // reference scrambler: one valid bit, then sample at the next falling edge
   task automatic tx(input logic plain);
      logic k;
      k      = ref_st[10] ^ ref_st[8];
      ref_st = {ref_st[9:0], k};
      rx_bit = plain ^ k;
      rx_vld = 1'b1;
      @(negedge clk);
   endtask

   task automatic gap();
      rx_vld = 1'b0;
      rx_bit = 1'($urandom_range(0, 1));
      @(negedge clk);
   endtask

   task automatic do_reset(input logic [10:0] seed);
      rx_vld = 1'b0;
      rst_n  = 1'b0;
      ref_st = seed;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic t_reset();
      do_reset(11'h5a3);
      chk(locked == 1'b0, "R1 locked", int'(locked), 0);
      chk(sync_lost == 1'b0, "R1 sync_lost", int'(sync_lost), 0);
      chk(dout_vld == 1'b0, "R1 dout_vld", int'(dout_vld), 0);
   endtask

   task automatic t_acquire();
      int early = 0;
      int dv = 0;
      do_reset(11'h3c1);
      for (int i = 0; i < 50; i++) begin
         tx(1'b1);
         if (locked) early++;
         if (dout_vld) dv++;
      end
      chk(early == 0, "R2 no lock before 51 bits", early, 0);
      chk(dv == 0, "R5 dout_vld during acquisition", dv, 0);
      tx(1'b1);
      chk(locked == 1'b1, "R2 lock after 51st bit", int'(locked), 1);
   endtask

   task automatic t_break();
      int early = 0;
      int n = 39;
      do_reset(11'h2f7);
      for (int i = 0; i < 30; i++) tx(1'b1);
      tx(1'b0);
      for (int i = 0; i < 39; i++) begin
         tx(1'b1);
         if (locked) early++;
      end
      chk(early == 0, "R3 run restarted by bad bit", early, 0);
      while (!locked && n < 100) begin
         tx(1'b1);
         n++;
      end
      chk(n == 51, "R3 lock position after bad bit", n, 51);
   endtask

   task automatic t_descramble();
      int err = 0;
      int gerr = 0;
      int err2 = 0;
      logic p;
      do_reset(11'h6d5);
      for (int i = 0; i < 51; i++) tx(1'b1);
      chk(locked == 1'b1, "R2 lock for payload test", int'(locked), 1);
      for (int i = 0; i < 120; i++) begin
         if (i % 5 == 2) begin
            gap();
            if (dout_vld !== 1'b0) gerr++;
         end
         p = 1'($urandom_range(0, 1));
         tx(p);
         if (dout_vld !== 1'b1 || dout !== p) err++;
      end
      chk(err == 0, "R4 random payload mismatches", err, 0);
      chk(gerr == 0, "R9 dout_vld on invalid cycles", gerr, 0);
      for (int i = 0; i < 40; i++) begin
         p = 1'((i / 3) % 2);
         tx(p);
         if (dout_vld !== 1'b1 || dout !== p) err2++;
      end
      chk(err2 == 0, "R4 run payload mismatches", err2, 0);
   endtask

   task automatic t_starve();
      int cnt = 1;
      int early = 0;
      do_reset(11'h155);
      for (int i = 0; i < 51; i++) tx(1'b1);
      for (int i = 1; i <= 2 * HOLD; i++) begin
         tx(1'(i % 4 != 3));
         if (locked) cnt++;
         else break;
      end
      chk(cnt == HOLD, "R6 locked cycles without re-arm", cnt, HOLD);
      chk(sync_lost == 1'b1, "R6 sync_lost on drop", int'(sync_lost), 1);
      tx(1'b1);
      chk(sync_lost == 1'b0, "R6 sync_lost one cycle", int'(sync_lost), 0);
      for (int i = 0; i < 49; i++) begin
         tx(1'b1);
         if (locked) early++;
      end
      chk(early == 0, "R8 full reacquisition needed", early, 0);
      tx(1'b1);
      chk(locked == 1'b1, "R8 relock after 51 bits", int'(locked), 1);
   endtask

   task automatic t_rearm();
      int drops = 0;
      int cnt = 0;
      do_reset(11'h4e9);
      for (int i = 0; i < 51; i++) tx(1'b1);
      for (int i = 1; i <= HOLD - 21; i++) tx(1'(i % 4 != 3));
      tx(1'b0);
      for (int i = 0; i < SYMS * SB; i++) tx(1'b1);
      chk(locked == 1'b1, "R7 re-arm on expiry edge", int'(locked), 1);
      for (int i = 0; i < 3 * HOLD; i++) begin
         tx(1'b1);
         if (!locked) drops++;
      end
      chk(drops == 0, "R7 idle stream keeps lock", drops, 0);
      for (int i = 1; i <= 2 * HOLD; i++) begin
         tx(1'(i % 4 != 3));
         if (locked) cnt++;
         else break;
      end
      chk(cnt == HOLD - 1, "R7 reload to full window", cnt, HOLD - 1);
   endtask

   initial begin
      @(negedge clk);
      t_reset();
      t_acquire();
      t_break();
      t_descramble();
      t_starve();
      t_rearm();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule